// File: doc/BRIEF.md
# Packet FIFO ECC Fault Injector

This block sits on the write path of an ECC-protected packet FIFO, between the ECC encoder and the storage. It passes every write beat through with one cycle of latency. On request it inverts a chosen set of bit positions in exactly one beat, so that the decoder further down the path sees a known single- or multi-bit error. Software sets the bit pattern in a mask register and then sets a one-shot arm bit. The error is placed on the first beat of the next packet that starts, and the arm bit then clears by itself.

The block also holds two 8-bit counters of packets dropped for ECC reasons, one for the transmit FIFO and one for the receive FIFO. Each counter is fed by a single-cycle drop pulse. A counter stops at its maximum, and reading it through the register port returns its value and clears it. Register reads return data on the cycle after the read strobe.

Top module: `ecc_fault_injector`

## Requirements
- R1: After synchronous reset, the mask, the arm bit and both drop counters are zero, and out_valid, out_sop, out_data and reg_rdata are zero.
- R2: When the arm bit is set and a beat arrives with in_valid and in_sop both high, out_data on the next cycle equals in_data XOR mask.
- R3: A beat that does not start a packet (in_sop low), or any beat while the arm bit is clear, is passed unchanged. An arm set in the middle of a packet is applied only at the next start-of-packet beat.
- R4: The arm bit is set by writing 1 to bit 0 at byte offset 0x404, and writing 0 there has no effect. It clears on the cycle after the beat it corrupted, so each set corrupts exactly one beat. Reading 0x404 returns the arm bit in bit 0.
- R5: The mask is read and written at byte offset 0x400, using bits [DATA_W-1:0]. The transmit drop counter is at 0x420 and the receive drop counter at 0x424, with their count in bits [7:0] and bits [31:8] reading as zero. Any other address reads as zero.
- R6: A drop counter increments once per cycle in which its drop pulse is high. It stops at 255 and stays there until it is read.
- R7: Reading a drop counter returns its current value and clears it. If a drop pulse for that counter arrives in the same cycle as the read, the read returns the old value and the counter ends at 1.
- R8: reg_rdata carries the read value in the cycle after reg_rd is high and is zero otherwise. out_valid follows in_valid one cycle later, and out_sop follows in_valid AND in_sop one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| in_valid | input | 1 | Write beat valid from the encoder |
| in_sop | input | 1 | Beat is the first of a packet |
| in_data | input | DATA_W | Encoded word (data and check bits) |
| out_valid | output | 1 | Write beat valid toward the FIFO |
| out_sop | output | 1 | First beat of a packet toward the FIFO |
| out_data | output | DATA_W | Word toward the FIFO, possibly corrupted |
| tx_drop | input | 1 | Pulse: a transmit packet was dropped for ECC |
| rx_drop | input | 1 | Pulse: a receive packet was dropped for ECC |

## Verification
Two pairs of functions can fall in the same cycle. A counter read can meet a drop pulse for the same counter. A read of the arm bit can meet the start-of-packet beat that consumes the arm. The bench drives both pairs on the same clock edge. A behavioural model, compared on every cycle, expects the read to return the value held before the edge, the counter to end at 1, and the arm bit to read 1 once and then 0.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int ADDR_W = 12;
  localparam int REG_W  = 32;
  localparam int NCNT   = 2;   // index 0: transmit drops, index 1: receive drops

  localparam logic [ADDR_W-1:0] MASK_OFS   = 12'h400;
  localparam logic [ADDR_W-1:0] CTRL_OFS   = 12'h404;
  localparam logic [ADDR_W-1:0] TXDROP_OFS = 12'h420;
  localparam logic [ADDR_W-1:0] RXDROP_OFS = 12'h424;

  function automatic logic [ADDR_W-1:0] drop_ofs(input int idx);
    return (idx == 0) ? TXDROP_OFS : RXDROP_OFS;
  endfunction
endpackage

// File: rtl/fi_sat_counter.sv
module fi_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      // a clear does not lose an event arriving in the same cycle
      cnt <= {{(W-1){1'b0}}, inc};
    end else if (inc && cnt != MAX) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fi_inject_path.sv
module fi_inject_path #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [DATA_W-1:0] in_data,
  input  logic              arm,
  input  logic [DATA_W-1:0] mask,
  output logic              take,
  output logic              out_valid,
  output logic              out_sop,
  output logic [DATA_W-1:0] out_data
);
  // only a packet's first beat may consume a pending injection
  assign take = arm & in_valid & in_sop;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_sop   <= in_valid & in_sop;
      out_data  <= take ? (in_data ^ mask) : in_data;
    end
  end
endmodule

// File: rtl/ecc_fault_injector.sv
module ecc_fault_injector
  import fi_pkg::*;
#(
  parameter int DATA_W = 32,  // must not exceed REG_W
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic [DATA_W-1:0] out_data,
  input  logic              tx_drop,
  input  logic              rx_drop
);
  logic [DATA_W-1:0] mask_q;
  logic              arm_q;
  logic              take;
  logic              arm_set;
  logic [NCNT-1:0]   drop_in;
  logic [CNT_W-1:0]  cnt_q [NCNT];
  logic [CNT_W-1:0]  tx_cnt;
  logic [REG_W-1:0]  rd_mux;

  assign arm_set = reg_wr && (reg_addr == CTRL_OFS) && reg_wdata[0];
  assign drop_in = {rx_drop, tx_drop};
  assign tx_cnt  = cnt_q[0];

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == MASK_OFS) mask_q <= reg_wdata[DATA_W-1:0];
      // consumption clears, a new write re-arms
      arm_q <= (arm_q & ~take) | arm_set;
    end
  end

  fi_inject_path #(.DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_data   (in_data),
    .arm       (arm_q),
    .mask      (mask_q),
    .take      (take),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_data  (out_data)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    fi_sat_counter #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (drop_in[g]),
      .clr (reg_rd && reg_addr == drop_ofs(g)),
      .cnt (cnt_q[g])
    );
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    if (reg_addr == MASK_OFS) rd_mux = REG_W'(mask_q);
    if (reg_addr == CTRL_OFS) rd_mux = REG_W'(arm_q);
    for (int i = 0; i < NCNT; i++) begin
      if (reg_addr == drop_ofs(i)) rd_mux = REG_W'(cnt_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_rd ? rd_mux : '0;
  end
endmodule

// File: rtl/fi_checker.sv
module fi_checker
  import fi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              in_valid,
  input logic              in_sop,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              tx_drop,
  input logic              arm_q,
  input logic [DATA_W-1:0] mask_q,
  input logic [CNT_W-1:0]  tx_cnt
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (tx_cnt == '0 && !arm_q && mask_q == '0 && !out_valid));

  a_r2_inject: assert property (@(posedge clk) disable iff (rst)
    (arm_q && in_valid && in_sop) |=> out_data == ($past(in_data) ^ $past(mask_q)));

  a_r3_passthrough: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sop) |=> out_data == $past(in_data));

  a_r4_arm_clears: assert property (@(posedge clk) disable iff (rst)
    (arm_q && in_valid && in_sop &&
     !(reg_wr && reg_addr == CTRL_OFS && reg_wdata[0])) |=> !arm_q);

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == TXDROP_OFS) |=> reg_rdata[REG_W-1:CNT_W] == '0);

  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt == CMAX && !(reg_rd && reg_addr == TXDROP_OFS)) |=> tx_cnt == CMAX);

  a_r7_read_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == TXDROP_OFS) |=> tx_cnt == CNT_W'($past(tx_drop)));

  a_r8_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
endmodule

bind ecc_fault_injector fi_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .in_valid  (in_valid),
  .in_sop    (in_sop),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .tx_drop   (tx_drop),
  .arm_q     (arm_q),
  .mask_q    (mask_q),
  .tx_cnt    (tx_cnt)
);

// File: tb/ecc_fault_injector_tb.sv
module ecc_fault_injector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0, in_sop = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic        out_valid, out_sop;
  logic [DW-1:0] out_data;
  logic        tx_drop = 1'b0, rx_drop = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit model_on = 0;
  string phase = "R1 reset";

  // reference model state
  logic [31:0] m_mask;
  bit          m_arm;
  int          m_tx, m_rx;
  bit          e_ov, e_osop;
  logic [31:0] e_od, e_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_fault_injector u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data),
    .tx_drop(tx_drop), .rx_drop(rx_drop)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // behavioural model: evaluates on pre-edge state, then updates
  always @(posedge clk) begin
    if (rst) begin
      m_mask = '0; m_arm = 0; m_tx = 0; m_rx = 0;
      e_ov = 0; e_osop = 0; e_od = '0; e_rd = '0;
    end else begin
      bit take;
      take = m_arm && in_valid && in_sop;
      e_ov = in_valid;
      e_osop = in_valid && in_sop;
      e_od = take ? (in_data ^ m_mask) : in_data;
      e_rd = '0;
      if (reg_rd) begin
        case (reg_addr)
          12'h400: e_rd = m_mask;
          12'h404: e_rd = {31'd0, m_arm};
          12'h420: e_rd = m_tx;
          12'h424: e_rd = m_rx;
          default: e_rd = '0;
        endcase
      end
      if (take) m_arm = 0;
      if (reg_wr && reg_addr == 12'h404 && reg_wdata[0]) m_arm = 1;
      if (reg_wr && reg_addr == 12'h400) m_mask = reg_wdata;
      if (reg_rd && reg_addr == 12'h420) m_tx = tx_drop ? 1 : 0;
      else if (tx_drop && m_tx < 255) m_tx++;
      if (reg_rd && reg_addr == 12'h424) m_rx = rx_drop ? 1 : 0;
      else if (rx_drop && m_rx < 255) m_rx++;
      model_on = 1;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (model_on && !finished) begin
      chk({phase, " out_valid"}, {31'd0, out_valid}, {31'd0, e_ov});
      chk({phase, " out_sop"}, {31'd0, out_sop}, {31'd0, e_osop});
      if (e_ov) chk({phase, " out_data"}, out_data, e_od);
      chk({phase, " rdata"}, reg_rdata, e_rd);
    end
  end

  task automatic rd(logic [11:0] a);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0; reg_addr = '0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic beat(bit sop, logic [31:0] d);
    in_valid = 1; in_sop = sop; in_data = d;
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_data = '0;
  endtask

  task automatic pkt(int n, logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_sop = (i == 0); in_data = base + 32'h1111_0000 * i;
      @(negedge clk);
    end
    in_valid = 0; in_sop = 0; in_data = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: run hung act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero while in reset
    chk("R1 reset outputs", {reg_rdata[31:0]}, 32'd0);
    chk("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    rst = 0;
    @(negedge clk);
    phase = "R1 reset state";
    rd(12'h400); rd(12'h404); rd(12'h420); rd(12'h424);

    phase = "R3 R8 passthrough";
    wr(12'h400, 32'hA5A5_0F0F);
    pkt(3, 32'h0000_1234);
    rd(12'h400);

    phase = "R2 inject idle arm";
    wr(12'h404, 32'h1);
    rd(12'h404);
    @(negedge clk);
    pkt(3, 32'h0BAD_CAFE);
    phase = "R4 arm self clears";
    rd(12'h404);
    pkt(2, 32'h1357_9BDF);
    wr(12'h404, 32'h0);
    rd(12'h404);
    pkt(1, 32'h2222_2222);

    phase = "R3 mid packet arm";
    beat(1, 32'h4444_0001);
    wr(12'h404, 32'h1);
    beat(0, 32'h4444_0002);
    beat(0, 32'h4444_0003);
    rd(12'h404);
    phase = "R2 next sop after mid arm";
    pkt(2, 32'h5555_0000);
    rd(12'h404);

    phase = "R4 ctrl read on consuming beat";
    wr(12'h400, 32'h8000_0001);
    wr(12'h404, 32'h1);
    reg_rd = 1; reg_addr = 12'h404; in_valid = 1; in_sop = 1; in_data = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_rd = 0; reg_addr = '0; in_valid = 0; in_sop = 0; in_data = '0;
    rd(12'h404);

    phase = "R7 tx count and clear";
    for (int i = 0; i < 3; i++) begin
      tx_drop = 1; @(negedge clk); tx_drop = 0; @(negedge clk);
    end
    rd(12'h420);
    rd(12'h420);

    phase = "R6 rx saturation";
    rx_drop = 1;
    repeat (300) @(negedge clk);
    rx_drop = 0;
    rd(12'h424);
    // R5: upper bits of counter register are zero, count at 255
    chk("R5 upper bits", {8'd0, reg_rdata[31:8]}, 32'd0);
    chk("R6 saturated value", {24'd0, reg_rdata[7:0]}, 32'd255);
    rd(12'h424);

    phase = "R7 read with same-cycle drop";
    tx_drop = 1; @(negedge clk); tx_drop = 0; @(negedge clk);
    reg_rd = 1; reg_addr = 12'h420; tx_drop = 1;
    @(negedge clk);
    reg_rd = 0; reg_addr = '0; tx_drop = 0;
    rd(12'h420);

    phase = "R5 unmapped address";
    rd(12'h408);
    rd(12'h000);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule